// File: doc/BRIEF.md
# Utility Interrupt Mask and Level Encoder

This block collects the utility interrupt events of a VMEbus interface and presents them to the local processor as one 3-bit interrupt priority level. There are seven sources. Two are global attention signals, one at low priority and one at high priority. Two are location-monitor hits. One marks the end of an outgoing IACK cycle. One is a posted-write bus error. The last is the SYSFAIL* line. The bus-facing logic, the address compare and the write datapath all sit outside this block, and they deliver their events as single-cycle pulses.

Each event sets a sticky pending flag, whether or not its source is masked. Software masks each source through a byte-wide enable register, and a separate master enable gates the combined request. Pending flags are cleared in one of two ways: software writes 1 to the flag's position in the status clear, or the processor acknowledges the flag's level. SYSFAIL* is level-sensitive, so its flag simply follows the line. The output level is registered and is the highest fixed level among the flags that are both pending and enabled.

Top module: `util_irq_ctrl`

## Requirements
- R1: After reset, the enable register, all pending flags and `ipl_o` are 0.
- R2: A write with `en_we_i` loads bits 7:1 of `en_wdata_i` into the enable register on the next clock. Bit 0 is reserved and always reads 0. Without a write the register holds its value.
- R3: A pulse on `evt_i` bit 1, 2, 3, 4, 5 or 7 sets the matching `pend_o` bit on the next clock, whether or not that source is enabled. The bit then stays set until it is cleared. Bits 0 and 6 of `evt_i` are ignored.
- R4: A write with `clr_we_i` clears every edge-source pending bit whose `clr_wdata_i` bit is 1. If a new event for a bit arrives in the same cycle as its clear, the event wins and the bit stays set.
- R5: When `ack_i` is high, every edge-source pending bit whose fixed level equals `ack_lvl_i` is cleared on the next clock. Flags at other levels are not affected.
- R6: `pend_o[6]` equals the inverse of `sysfail_ni` as sampled at the previous clock edge. It is not affected by the clear write or by acknowledge.
- R7: The source bits have these fixed levels: bit 1 low attention → 1, bit 3 IACK done → 2, bits 2 and 4 location monitors → 3, bit 5 high attention → 5, bit 6 SYSFAIL* → 6, bit 7 posted-write error → 7.
- R8: One clock after the pending and enable state is formed, `ipl_o` shows the highest level among the bits that are both pending and enabled.
- R9: When `master_en_i` is 0, `ipl_o` is 0 on the next clock.
- R10: A pending bit whose enable bit is 0 does not contribute to `ipl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_rdata_o | output | 8 | Enable register contents |
| clr_we_i | input | 1 | Pending clear write strobe |
| clr_wdata_i | input | 8 | Write-1-to-clear mask for the pending flags |
| pend_o | output | 8 | Pending flags |
| evt_i | input | 8 | Single-cycle event pulses, one per source bit |
| sysfail_ni | input | 1 | SYSFAIL* line, active low |
| master_en_i | input | 1 | Master interrupt enable |
| ack_i | input | 1 | Processor interrupt acknowledge |
| ack_lvl_i | input | 3 | Level being acknowledged |
| ipl_o | output | 3 | Encoded interrupt priority level, 0 when idle |

## Verification
Directed sequences raise each source alone with only its enable set. This tells one fixed level apart from another, and it shows a masked but pending source staying silent. Overlapping events, with a clear or an acknowledge in the same cycle, separate the set-wins rule from plain clearing. They also show that an acknowledge at one level leaves the other levels intact. Long random runs mix sparse events, enable rewrites, master toggles and SYSFAIL* changes. These runs check that the maximum is chosen correctly while several levels are pending and the mask keeps changing.

// File: rtl/util_irq_pkg.sv
package util_irq_pkg;
  localparam int unsigned NSRC  = 8;
  localparam int unsigned LVL_W = 3;
  localparam int unsigned SYSFAIL_BIT = 6;

  typedef logic [NSRC-1:0]  src_vec_t;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam src_vec_t IMPL_MASK  = src_vec_t'(8'hFE);
  localparam src_vec_t LEVEL_MASK = src_vec_t'(1) << SYSFAIL_BIT;
  localparam src_vec_t EDGE_MASK  = IMPL_MASK & ~LEVEL_MASK;

  function automatic lvl_t src_level(int unsigned idx);
    case (idx)
      1:       return lvl_t'(1);
      2, 4:    return lvl_t'(3);
      3:       return lvl_t'(2);
      5:       return lvl_t'(5);
      6:       return lvl_t'(6);
      7:       return lvl_t'(7);
      default: return lvl_t'(0);
    endcase
  endfunction
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import util_irq_pkg::*;
#(
  parameter int unsigned W = NSRC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  localparam logic [W-1:0] MASK = W'(IMPL_MASK);

  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (we_i) en_q <= wdata_i & MASK;
  end

  assign en_o = en_q;

  assert_en_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> en_o == ($past(wdata_i) & MASK));
  assert_en_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_o));
endmodule

// File: rtl/irq_pending.sv
module irq_pending
  import util_irq_pkg::*;
#(
  parameter int unsigned W  = NSRC,
  parameter int unsigned LW = LVL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  evt_i,
  input  logic          sysfail_ni,
  input  logic          clr_we_i,
  input  logic [W-1:0]  clr_wdata_i,
  input  logic          ack_i,
  input  logic [LW-1:0] ack_lvl_i,
  output logic [W-1:0]  pend_o
);
  localparam logic [W-1:0] EDGES = W'(EDGE_MASK);

  logic [W-1:0] set_vec, clr_vec, ack_vec, pend_q;

  assign set_vec = evt_i & EDGES;
  assign clr_vec = clr_we_i ? (clr_wdata_i & EDGES) : '0;

  for (genvar i = 0; i < W; i++) begin : g_src
    if (EDGES[i]) begin : g_edge
      assign ack_vec[i] = ack_i && (ack_lvl_i == LW'(src_level(i)));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q[i] <= 1'b0;
        else         pend_q[i] <= set_vec[i] | (pend_q[i] & ~clr_vec[i] & ~ack_vec[i]);
      end
      assert_evt_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i[i] |=> pend_o[i]);
      assert_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pend_o[i] && !(clr_we_i && clr_wdata_i[i]) && !ack_vec[i] |=> pend_o[i]);
      assert_ack_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_vec[i] && !evt_i[i] |=> !pend_o[i]);
    end else if (i == SYSFAIL_BIT) begin : g_level
      assign ack_vec[i] = 1'b0;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q[i] <= 1'b0;
        else         pend_q[i] <= ~sysfail_ni;
      end
      assert_sysfail_track_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> pend_o[i] == !$past(sysfail_ni));
    end else begin : g_rsvd
      assign ack_vec[i] = 1'b0;
      assign pend_q[i]  = 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import util_irq_pkg::*;
#(
  parameter int unsigned W  = NSRC,
  parameter int unsigned LW = LVL_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  pend_i,
  input  logic [W-1:0]  en_i,
  input  logic          master_en_i,
  output logic [LW-1:0] ipl_o
);
  logic [W-1:0]  act;
  logic [LW-1:0] best, ipl_q;

  assign act = pend_i & en_i;

  always_comb begin
    best = '0;
    for (int unsigned i = 0; i < W; i++) begin
      if (act[i] && (LW'(src_level(i)) > best)) best = LW'(src_level(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ipl_q <= '0;
    else         ipl_q <= master_en_i ? best : '0;
  end

  assign ipl_o = ipl_q;

  assert_master_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_en_i |=> ipl_o == '0);
  assert_masked_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i & en_i) == '0 |=> ipl_o == '0);
  assert_level_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_en_i && pend_i[7] && en_i[7] |=> ipl_o == LW'(7));
endmodule

// File: rtl/util_irq_ctrl.sv
module util_irq_ctrl
  import util_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_we_i,
  input  logic [NSRC-1:0]  en_wdata_i,
  output logic [NSRC-1:0]  en_rdata_o,
  input  logic             clr_we_i,
  input  logic [NSRC-1:0]  clr_wdata_i,
  output logic [NSRC-1:0]  pend_o,
  input  logic [NSRC-1:0]  evt_i,
  input  logic             sysfail_ni,
  input  logic             master_en_i,
  input  logic             ack_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  output logic [LVL_W-1:0] ipl_o
);
  logic [NSRC-1:0] en, pend;

  irq_enable_reg #(.W(NSRC)) u_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (en_we_i),
    .wdata_i (en_wdata_i),
    .en_o    (en)
  );

  irq_pending #(.W(NSRC), .LW(LVL_W)) u_pend (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt_i),
    .sysfail_ni  (sysfail_ni),
    .clr_we_i    (clr_we_i),
    .clr_wdata_i (clr_wdata_i),
    .ack_i       (ack_i),
    .ack_lvl_i   (ack_lvl_i),
    .pend_o      (pend)
  );

  irq_prio_enc #(.W(NSRC), .LW(LVL_W)) u_enc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (pend),
    .en_i        (en),
    .master_en_i (master_en_i),
    .ipl_o       (ipl_o)
  );

  assign en_rdata_o = en;
  assign pend_o     = pend;
endmodule

// File: tb/util_irq_ctrl_test.sv
module util_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_we = 1'b0, clr_we = 1'b0, ack = 1'b0;
  logic [7:0] en_wd = '0, clr_wd = '0, evt = '0;
  logic       sysfail_n = 1'b1, master = 1'b0;
  logic [2:0] ack_lvl = '0;
  logic [7:0] en_rd, pend;
  logic [2:0] ipl;

  logic [7:0] en_m = '0, pend_m = '0;
  logic [2:0] ipl_m = '0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  util_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .en_we_i(en_we), .en_wdata_i(en_wd),
    .en_rdata_o(en_rd), .clr_we_i(clr_we), .clr_wdata_i(clr_wd), .pend_o(pend),
    .evt_i(evt), .sysfail_ni(sysfail_n), .master_en_i(master), .ack_i(ack),
    .ack_lvl_i(ack_lvl), .ipl_o(ipl)
  );

  function automatic logic [2:0] lvl_of(int b);
    case (b)
      1: return 3'd1;  2: return 3'd3;  3: return 3'd2;  4: return 3'd3;
      5: return 3'd5;  6: return 3'd6;  7: return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] max_lvl(logic [7:0] act);
    logic [2:0] m = 3'd0;
    for (int b = 0; b < 8; b++) if (act[b] && lvl_of(b) > m) m = lvl_of(b);
    return m;
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] nxt;
    ipl_m = master ? max_lvl(pend_m & en_m) : 3'd0;
    for (int b = 0; b < 8; b++) begin
      if (b == 0) nxt[b] = 1'b0;
      else if (b == 6) nxt[b] = ~sysfail_n;
      else nxt[b] = evt[b] | (pend_m[b] & ~(clr_we & clr_wd[b]) & ~(ack && ack_lvl == lvl_of(b)));
    end
    pend_m = nxt;
    if (en_we) en_m = en_wd & 8'hFE;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    en_we = 0; clr_we = 0; ack = 0; evt = '0;
    check(tag, "en_rdata", en_rd, en_m);
    check(tag, "pend", pend, pend_m);
    check(tag, "ipl", {5'd0, ipl}, {5'd0, ipl_m});
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    check("R1", "en_rdata", en_rd, 8'h00);
    check("R1", "pend", pend, 8'h00);
    check("R1", "ipl", {5'd0, ipl}, 8'h00);

    // R2 write with reserved bit
    en_we = 1; en_wd = 8'hFF; step("R2");
    check("R2", "en_rdata literal", en_rd, 8'hFE);
    en_we = 1; en_wd = 8'h00; step("R2");

    // R3 / R10: masked pending stays silent, sticky
    master = 1; evt = 8'h20; step("R3");
    step("R10");
    check("R10", "ipl masked", {5'd0, ipl}, 8'h00);
    step("R3");
    check("R3", "pend sticky", pend, 8'h20);
    evt = 8'h41; step("R3");
    check("R3", "bits 0 and 6 ignored", pend, 8'h20);

    // R8 max level
    en_we = 1; en_wd = 8'hFE; step("R8");
    step("R8");
    check("R8", "ipl level5", {5'd0, ipl}, 8'h05);
    evt = 8'h80; step("R8"); step("R8");
    check("R8", "ipl level7", {5'd0, ipl}, 8'h07);

    // R5 ack level 7 only
    ack = 1; ack_lvl = 3'd7; step("R5"); step("R5");
    check("R5", "ipl after ack", {5'd0, ipl}, 8'h05);

    // R4 clear and set-wins
    clr_we = 1; clr_wd = 8'hFF; step("R4");
    check("R4", "pend cleared", pend, 8'h00);
    evt = 8'h02; clr_we = 1; clr_wd = 8'h02; step("R4");
    check("R4", "set wins", pend, 8'h02);

    // R9 master gate
    master = 0; step("R9"); step("R9");
    check("R9", "ipl gated", {5'd0, ipl}, 8'h00);
    master = 1;

    // R6 sysfail level source
    sysfail_n = 0; step("R6");
    check("R6", "pend6 set", pend & 8'h40, 8'h40);
    clr_we = 1; clr_wd = 8'h40; ack = 1; ack_lvl = 3'd6; step("R6");
    check("R6", "pend6 kept", pend & 8'h40, 8'h40);
    check("R6", "ipl level6", {5'd0, ipl}, 8'h06);
    sysfail_n = 1; step("R6"); step("R6");

    // R7 each source alone
    for (int b = 1; b < 8; b++) begin
      clr_we = 1; clr_wd = 8'hFF; en_we = 1; en_wd = 8'(1 << b); step("R7");
      if (b == 6) sysfail_n = 0; else evt = 8'(1 << b);
      step("R7"); step("R7");
      check("R7", "ipl single source", {5'd0, ipl}, {5'd0, lvl_of(b)});
      sysfail_n = 1; step("R7");
    end

    // R8 random mix
    for (int n = 0; n < 3000; n++) begin
      evt       = 8'($urandom) & 8'($urandom) & 8'($urandom);
      en_we     = ($urandom % 8) == 0; en_wd = 8'($urandom);
      clr_we    = ($urandom % 6) == 0; clr_wd = 8'($urandom);
      ack       = ($urandom % 5) == 0; ack_lvl = 3'($urandom);
      if (($urandom % 20) == 0) master = ~master;
      if (($urandom % 30) == 0) sysfail_n = ~sysfail_n;
      step("R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule